// File: doc/BRIEF.md
# Adapter Reset and Init Sequencer

This block brings a network adapter's glue logic out of reset and into working order by issuing byte writes to three of its control registers: a reset control register, an interrupt control register and a FIFO threshold register. The reset control register holds active-low release bits for three domains: the chip core, the system interface and the FIFO. The block keeps a shadow copy of that register. Every change it makes is a read-modify-write of the shadow, so no bit outside the change is disturbed.

Three one-cycle requests drive it. An enable request releases only the chip core. An open request sets the chip bit, asserts all three domains together, waits a programmable settle time, and then releases the domains one at a time in a fixed order. After that it enables the interrupts and sets the FIFO threshold. A close request clears the whole reset register. Register offsets and bit positions are parameters. A one-cycle done pulse marks the end of every sequence.

Top module: `adp_init_seq`

## Requirements
- R1: While reset is held and after it is released with no request, `wr_en` and `done` stay low. The shadow copy starts at zero.
- R2: An enable request causes exactly one write, to the reset register (offset 1), with data equal to the shadow with the chip bit (bit 0) set. All other bits keep their shadow value.
- R3: An open request first writes the reset register with the chip bit set in the shadow. In the next cycle it writes the reset register with the chip, system-interface (bit 1) and FIFO (bit 2) bits all cleared in one write.
- R4: Between the all-clear write and the first release write there are exactly `settle_cycles`+1 cycles with `wr_en` low.
- R5: After the wait, open writes the reset register three times in consecutive cycles. Each write adds one bit to the shadow, in the order chip, system interface, FIFO. Starting from a zero shadow, the data is 0x01, 0x03, 0x07.
- R6: In the cycle after the FIFO release, open writes 0x22 to the interrupt control register (offset 4). That value is the system-interface interrupt enable (bit 1) plus the bus error enable (bit 5).
- R7: The last write of open puts the value 30 (0x1E) into the FIFO threshold register (offset 6), in the cycle after the interrupt write. Open makes seven writes in all.
- R8: A close request causes exactly one write: 0x00 to the reset register.
- R9: A request that arrives while a sequence is running, up to and including the cycle of its last write, is ignored. It causes no extra writes and does not change the running sequence.
- R10: `done` is high for exactly one cycle, in the cycle after the last write of each sequence. A request presented in that cycle is accepted.
- R11: When several requests arrive together in idle, close wins over open, and open wins over enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_req | input | 1 | Start the full open sequence |
| close_req | input | 1 | Put every domain back in reset |
| enable_req | input | 1 | Release the chip core only |
| settle_cycles | input | SETTLE_W | Settle wait after the reset assert, minus one |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register offset of the write |
| wr_data | output | DATA_W | Write data |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two events can fall on the same cycle: the done pulse of one sequence and the arrival of a new request. The bench waits until done is high and presents an open request in that same cycle. It judges the case by whether a complete seven-write open sequence follows. As the opposite case, it raises close during the final threshold write of an open. No further write may appear afterwards.

// File: rtl/adp_init_pkg.sv
package adp_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EN_SET,
    ST_CL_CLR,
    ST_OP_PRE,
    ST_OP_ASSERT,
    ST_OP_WAIT,
    ST_OP_CHIP,
    ST_OP_SIF,
    ST_OP_FIFO,
    ST_OP_IRQ,
    ST_OP_THR
  } seq_st_e;

  typedef enum logic [2:0] {
    RMW_NONE,
    RMW_SET_CHIP,
    RMW_SET_SIF,
    RMW_SET_FIFO,
    RMW_CLR_ALL,
    RMW_ZERO
  } rmw_op_e;

endpackage

// File: rtl/adp_settle_timer.sv
module adp_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                run,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                zero
);

  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | (run & ~zero);

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (run) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("timer"); // R4

endmodule

// File: rtl/adp_rst_shadow.sv
module adp_rst_shadow
  import adp_init_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BIT_CHIP = 0,
  parameter int BIT_SIF  = 1,
  parameter int BIT_FIFO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rmw_op_e           op,
  output logic [DATA_W-1:0] shadow,
  output logic [DATA_W-1:0] next_val
);

  localparam logic [DATA_W-1:0] ONE    = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] M_CHIP = ONE << BIT_CHIP;
  localparam logic [DATA_W-1:0] M_SIF  = ONE << BIT_SIF;
  localparam logic [DATA_W-1:0] M_FIFO = ONE << BIT_FIFO;

  logic [DATA_W-1:0] shadow_q;
  logic              commit;

  assign shadow = shadow_q;
  assign commit = (op != RMW_NONE);

  always_comb begin
    unique case (op)
      RMW_SET_CHIP: next_val = shadow_q | M_CHIP;
      RMW_SET_SIF:  next_val = shadow_q | M_SIF;
      RMW_SET_FIFO: next_val = shadow_q | M_FIFO;
      RMW_CLR_ALL:  next_val = shadow_q & ~(M_CHIP | M_SIF | M_FIFO);
      RMW_ZERO:     next_val = '0;
      default:      next_val = shadow_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= '0;
    else if (commit) shadow_q <= next_val;
  end

endmodule

// File: rtl/adp_init_fsm.sv
module adp_init_fsm
  import adp_init_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    open_req,
  input  logic    close_req,
  input  logic    enable_req,
  input  logic    timer_zero,
  output seq_st_e state,
  output logic    done
);

  seq_st_e state_q, state_d;
  logic    done_q, done_d;

  assign state = state_q;
  assign done  = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (close_req)       state_d = ST_CL_CLR;
        else if (open_req)   state_d = ST_OP_PRE;
        else if (enable_req) state_d = ST_EN_SET;
      end
      ST_OP_PRE:    state_d = ST_OP_ASSERT;
      ST_OP_ASSERT: state_d = ST_OP_WAIT;
      ST_OP_WAIT:   if (timer_zero) state_d = ST_OP_CHIP;
      ST_OP_CHIP:   state_d = ST_OP_SIF;
      ST_OP_SIF:    state_d = ST_OP_FIFO;
      ST_OP_FIFO:   state_d = ST_OP_IRQ;
      ST_OP_IRQ:    state_d = ST_OP_THR;
      default:      state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_EN_SET) || (state_q == ST_CL_CLR) || (state_q == ST_OP_THR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done width"); // R10
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OP_WAIT) |=> (state_q == ST_OP_WAIT || state_q == ST_OP_CHIP)) else $error("wait diverted"); // R9

endmodule

// File: rtl/adp_init_seq.sv
module adp_init_seq
  import adp_init_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SETTLE_W    = 8,
  parameter int RST_ADDR    = 1,
  parameter int IRQ_ADDR    = 4,
  parameter int THR_ADDR    = 6,
  parameter int BIT_CHIP    = 0,
  parameter int BIT_SIF     = 1,
  parameter int BIT_FIFO    = 2,
  parameter int BIT_SINT    = 1,
  parameter int BIT_PERR    = 5,
  parameter int FIFO_THRESH = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                open_req,
  input  logic                close_req,
  input  logic                enable_req,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic                done
);

  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] IRQ_VAL = (ONE << BIT_SINT) | (ONE << BIT_PERR);
  localparam logic [DATA_W-1:0] THR_VAL = DATA_W'(FIFO_THRESH);
  localparam logic [ADDR_W-1:0] A_RST   = ADDR_W'(RST_ADDR);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(IRQ_ADDR);
  localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(THR_ADDR);

  seq_st_e           state;
  rmw_op_e           rmw_op;
  logic              timer_zero;
  logic [DATA_W-1:0] shadow, rmw_val;

  adp_init_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_req   (open_req),
    .close_req  (close_req),
    .enable_req (enable_req),
    .timer_zero (timer_zero),
    .state      (state),
    .done       (done)
  );

  adp_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == ST_OP_ASSERT),
    .run      (state == ST_OP_WAIT),
    .load_val (settle_cycles),
    .zero     (timer_zero)
  );

  adp_rst_shadow #(
    .DATA_W(DATA_W), .BIT_CHIP(BIT_CHIP), .BIT_SIF(BIT_SIF), .BIT_FIFO(BIT_FIFO)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (rmw_op),
    .shadow   (shadow),
    .next_val (rmw_val)
  );

  always_comb begin
    unique case (state)
      ST_EN_SET, ST_OP_PRE, ST_OP_CHIP: rmw_op = RMW_SET_CHIP;
      ST_OP_ASSERT:                     rmw_op = RMW_CLR_ALL;
      ST_OP_SIF:                        rmw_op = RMW_SET_SIF;
      ST_OP_FIFO:                       rmw_op = RMW_SET_FIFO;
      ST_CL_CLR:                        rmw_op = RMW_ZERO;
      default:                          rmw_op = RMW_NONE;
    endcase
  end

  always_comb begin
    wr_en   = 1'b1;
    wr_addr = A_RST;
    wr_data = rmw_val;
    if (state == ST_OP_IRQ) begin
      wr_addr = A_IRQ;
      wr_data = IRQ_VAL;
    end else if (state == ST_OP_THR) begin
      wr_addr = A_THR;
      wr_data = THR_VAL;
    end else if (rmw_op == RMW_NONE) begin
      wr_en   = 1'b0;
      wr_data = '0;
    end
  end

  AST_SHADOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RST) |=> (shadow == $past(wr_data))) else $error("shadow"); // R2
  AST_SIF_AFTER_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RST && wr_data[BIT_SIF] && !shadow[BIT_SIF]) |-> shadow[BIT_CHIP]) else $error("order sif"); // R5
  AST_FIFO_AFTER_SIF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RST && wr_data[BIT_FIFO] && !shadow[BIT_FIFO]) |-> shadow[BIT_SIF]) else $error("order fifo"); // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en)) else $error("done without write"); // R10

endmodule

// File: tb/adp_init_seq_tb.sv
`timescale 1ns/1ps
module adp_init_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       open_req = 1'b0, close_req = 1'b0, enable_req = 1'b0;
  logic [7:0] settle_cycles = 8'd0;
  logic       wr_en, done;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;

  always #5 clk = ~clk;

  adp_init_seq dut_i (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .close_req(close_req),
    .enable_req(enable_req), .settle_cycles(settle_cycles),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  int errors = 0, checks = 0, cyc = 0, n = 0, done_cnt = 0;
  logic [3:0] log_a [256];
  logic [7:0] log_d [256];
  int         log_c [256];
  bit         finished = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wr_en && n < 256) begin
      log_a[n] <= wr_addr; log_d[n] <= wr_data; log_c[n] <= cyc; n <= n + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit o, input bit c, input bit e);
    @(posedge clk); #1; open_req = o; close_req = c; enable_req = e;
    @(posedge clk); #1; open_req = 0; close_req = 0; enable_req = 0;
  endtask

  task automatic wait_done(input int dbase);
    for (int k = 0; k < 400 && done_cnt == dbase; k++) begin
      @(posedge clk); #1;
    end
    repeat (4) begin @(posedge clk); #1; end
  endtask

  localparam logic [33:0] VEC [6] = '{
    {2'd0, 8'd0, 4'd1, 4'h1, 8'h01, 8'h01},
    {2'd1, 8'd3, 4'd7, 4'h6, 8'h1E, 8'h01},
    {2'd0, 8'd0, 4'd1, 4'h1, 8'h07, 8'h07},
    {2'd2, 8'd0, 4'd1, 4'h1, 8'h00, 8'h00},
    {2'd1, 8'd0, 4'd7, 4'h6, 8'h1E, 8'h01},
    {2'd2, 8'd0, 4'd1, 4'h1, 8'h00, 8'h00}
  };

  function automatic logic [11:0] open_exp(input int i, input logic [7:0] first);
    case (i)
      0: return {4'h1, first};
      1: return {4'h1, 8'h00};
      2: return {4'h1, 8'h01};
      3: return {4'h1, 8'h03};
      4: return {4'h1, 8'h07};
      5: return {4'h4, 8'h22};
      default: return {4'h6, 8'h1E};
    endcase
  endfunction

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, dbase;
    repeat (3) @(posedge clk);
    #1;
    chk(!wr_en && !done, "R1 during reset", {wr_en, done}, 0);
    rst_n = 1;
    repeat (5) begin @(posedge clk); #1; end
    chk(n == 0 && done_cnt == 0, "R1 idle after reset", n, 0);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] op; logic [7:0] st; logic [3:0] nw, la; logic [7:0] ld, fd;
      {op, st, nw, la, ld, fd} = VEC[v];
      settle_cycles = st;
      base = n; dbase = done_cnt;
      pulse(op == 1, op == 2, op == 0);
      wait_done(dbase);
      chk(n - base == int'(nw), "R2/R7/R8 write count", n - base, nw);
      chk(done_cnt - dbase == 1, "R10 one done", done_cnt - dbase, 1);
      chk(log_d[base] == fd, "R2/R3 first data", log_d[base], fd);
      chk(log_a[n-1] == la && log_d[n-1] == ld, "R6/R7/R8 last write",
          {log_a[n-1], log_d[n-1]}, {la, ld});
      if (op == 1) begin
        for (int i = 0; i < 7; i++)
          chk({log_a[base+i], log_d[base+i]} == open_exp(i, fd), "R3/R5/R6 open sequence",
              {log_a[base+i], log_d[base+i]}, open_exp(i, fd));
        chk(log_c[base+2] - log_c[base+1] == int'(st) + 2, "R4 settle gap",
            log_c[base+2] - log_c[base+1], int'(st) + 2);
        chk(log_c[base+1] - log_c[base] == 1 && log_c[base+6] - log_c[base+2] == 4,
            "R5 back-to-back", log_c[base+6] - log_c[base+2], 4);
      end
    end

    // R9: requests during a running open are ignored
    settle_cycles = 8'd20;
    base = n; dbase = done_cnt;
    pulse(1, 0, 0);
    repeat (5) begin @(posedge clk); #1; end
    pulse(0, 1, 1);
    wait_done(dbase);
    chk(n - base == 7, "R9 busy ignore count", n - base, 7);
    chk(log_d[base+6] == 8'h1E && log_a[base+6] == 4'h6, "R9 busy ignore last", log_d[base+6], 8'h1E);

    // R10: request in the done cycle is accepted
    settle_cycles = 8'd1;
    base = n; dbase = done_cnt;
    pulse(0, 0, 1);
    for (int k = 0; k < 50 && !done; k++) begin @(posedge clk); #1; end
    open_req = 1;
    @(posedge clk); #1; open_req = 0;
    wait_done(dbase + 1);
    chk(n - base == 8, "R10 request in done cycle accepted", n - base, 8);
    chk(log_d[base+1] == 8'h07 && log_a[n-1] == 4'h6, "R10 open follows", log_d[base+1], 8'h07);

    // R9: request during the last write is ignored
    base = n; dbase = done_cnt;
    pulse(1, 0, 0);
    for (int k = 0; k < 50 && !(wr_en && wr_addr == 4'h6); k++) begin @(posedge clk); #1; end
    close_req = 1;
    @(posedge clk); #1; close_req = 0;
    repeat (10) begin @(posedge clk); #1; end
    chk(n - base == 7, "R9 last-cycle request ignored", n - base, 7);

    // R11: priority among simultaneous requests
    base = n; dbase = done_cnt;
    pulse(1, 1, 1);
    wait_done(dbase);
    chk(n - base == 1 && log_d[base] == 8'h00, "R11 close wins", {n - base, log_d[base]}, 1 << 8);
    base = n; dbase = done_cnt;
    settle_cycles = 8'd0;
    pulse(1, 0, 1);
    wait_done(dbase);
    chk(n - base == 7, "R11 open beats enable", n - base, 7);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule